// File: doc/BRIEF.md
# Periodic Real-Time Tick Timer

This block produces a periodic interrupt request from the oscillator clock. A single control register selects the period. It has a prescale field, which picks a power-of-two divider, and a modulus field, which counts that many plus one divided ticks. At the end of every period a sticky flag is set. Software clears the flag by writing a one to its bit. The interrupt output is a level that is high while both the flag and an enable bit are set.

Any write to the control register restarts both counters, so the first flag after the write comes one full period later. A prescale value of zero holds the timer still, and no flags are produced while it is stopped. The register port is a simple single-cycle write strobe with a combinational read mux.

Top module: `rtt_timer`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is low.
- R2: With prescale p (1 to 7) and modulus m, the flag is first set exactly (m+1)·2^(BASE_SHIFT+p) clock edges after the edge that wrote the control register, and again every such period after that.
- R3: Address 0 is the control register, with prescale in bits 6:4 and modulus in bits 3:0. Bit 7 reads as 0. Address 1 holds the flag in bit 0, address 2 holds the interrupt enable in bit 0, and address 3 reads as 0.
- R4: Once set, the flag stays set, including across control writes and while the timer is stopped, until software clears it.
- R5: A write to address 1 with bit 0 set clears the flag. A write with bit 0 clear has no effect on it.
- R6: When a period ends in the same cycle as a clearing write, the flag stays set.
- R7: With prescale 0 the timer is stopped and the flag never sets.
- R8: Any control write restarts the count, so the next flag comes one full period after the latest write.
- R9: `irq` is a level equal to flag AND enable. It follows changes to either one without a pulse shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the timer with BASE_SHIFT set to 2 instead of 9, so the prescale taps are 8 to 512 cycles apart. This brings the longest period (prescale 7, modulus 15, 8192 cycles) and many random periods within the run length. The bench samples the flag one cycle before and exactly at the predicted edge. Field widths stay at their defaults, so the control layout checked by the bench is the same one the block is built with.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_FLAG  = 2'd1,
    RA_IEN   = 2'd2,
    RA_SPARE = 2'd3
  } rtt_addr_e;
endpackage

// File: rtl/rtt_regs.sv
module rtt_regs
  import rtt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PSEL_W = 3,
  parameter int MSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              period_evt,
  output logic [DATA_W-1:0] rdata,
  output logic [PSEL_W-1:0] pre_o,
  output logic [MSEL_W-1:0] mod_o,
  output logic              flag_o,
  output logic              ien_o,
  output logic              restart_o
);
  localparam int CTRL_W = PSEL_W + MSEL_W;

  rtt_addr_e   sel;
  logic        wr_ctrl, wr_flag, wr_ien, clr_req;
  logic [PSEL_W-1:0] pre_q, pre_d;
  logic [MSEL_W-1:0] mod_q, mod_d;
  logic        flag_q, flag_d;
  logic        ien_q, ien_d;

  assign sel     = rtt_addr_e'(addr);
  assign wr_ctrl = wr_en && (sel == RA_CTRL);
  assign wr_flag = wr_en && (sel == RA_FLAG);
  assign wr_ien  = wr_en && (sel == RA_IEN);
  assign clr_req = wr_flag && wdata[0];

  // next state
  always_comb begin
    pre_d = pre_q;
    mod_d = mod_q;
    if (wr_ctrl) begin
      pre_d = wdata[CTRL_W-1:MSEL_W];
      mod_d = wdata[MSEL_W-1:0];
    end
    flag_d = period_evt | (flag_q & ~clr_req);
    ien_d  = wr_ien ? wdata[0] : ien_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      mod_q  <= '0;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      mod_q  <= mod_d;
      flag_q <= flag_d;
      ien_q  <= ien_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (sel)
      RA_CTRL: rdata[CTRL_W-1:0] = {pre_q, mod_q};
      RA_FLAG: rdata[0] = flag_q;
      RA_IEN:  rdata[0] = ien_q;
      default: rdata = '0;
    endcase
  end

  assign pre_o     = pre_q;
  assign mod_o     = mod_q;
  assign flag_o    = flag_q;
  assign ien_o     = ien_q;
  assign restart_o = wr_ctrl;

  // R4: a set flag survives every cycle without a clearing write
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);

  // R5: the flag only falls after a clearing write
  a_r5_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_req));

  // R6: an end-of-period event always leaves the flag set
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> flag_q);
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int PSEL_W     = 3,
  parameter int BASE_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PSEL_W-1:0] pre,
  output logic              tick
);
  localparam int NSEL  = 1 << PSEL_W;
  localparam int CNT_W = BASE_SHIFT + NSEL - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run;
  logic [NSEL-1:0]  tap;

  assign run = (pre != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // one tap per prescale setting: low bits all ones ends a divided tick
  assign tap[0] = 1'b0;
  for (genvar p = 1; p < NSEL; p++) begin : g_tap
    assign tap[p] = &cnt_q[BASE_SHIFT+p-1:0];
  end

  assign tick = tap[pre] && !restart;

  // R8: a control write returns the divider to zero
  a_r8_prescale_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rtt_modulus.sv
module rtt_modulus #(
  parameter int MSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic [MSEL_W-1:0] mod,
  output logic              period_evt
);
  logic [MSEL_W-1:0] mcnt_q, mcnt_d;
  logic              at_end;

  assign at_end     = (mcnt_q == mod);
  assign period_evt = tick && at_end;

  always_comb begin
    mcnt_d = mcnt_q;
    if (restart)   mcnt_d = '0;
    else if (tick) mcnt_d = at_end ? '0 : mcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt_q <= '0;
    else        mcnt_q <= mcnt_d;
  end

  // R2: the count never passes the selected modulus
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt_q <= mod);

  // R8: a control write returns the modulus count to zero
  a_r8_modulus_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mcnt_q == '0));
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer #(
  parameter int DATA_W     = 8,
  parameter int PSEL_W     = 3,
  parameter int MSEL_W     = 4,
  parameter int BASE_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [PSEL_W-1:0] pre;
  logic [MSEL_W-1:0] mod;
  logic              flag, ien, restart, tick, period_evt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  rtt_regs #(.DATA_W(DATA_W), .PSEL_W(PSEL_W), .MSEL_W(MSEL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .period_evt (period_evt),
    .rdata      (rdata),
    .pre_o      (pre),
    .mod_o      (mod),
    .flag_o     (flag),
    .ien_o      (ien),
    .restart_o  (restart)
  );

  rtt_prescaler #(.PSEL_W(PSEL_W), .BASE_SHIFT(BASE_SHIFT)) u_presc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (restart),
    .pre     (pre),
    .tick    (tick)
  );

  rtt_modulus #(.MSEL_W(MSEL_W)) u_mod (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .restart    (restart),
    .tick       (tick),
    .mod        (mod),
    .period_evt (period_evt)
  );

  assign irq = flag & ien;

  // R7: a stopped timer produces no end-of-period event
  a_r7_stopped_silent: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pre == '0) |-> !period_evt);
endmodule

// File: tb/rtt_timer_bench.sv
`timescale 1ns/1ps
module rtt_timer_bench;
  localparam int BS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit en_model = 1'b0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  rtt_timer #(.BASE_SHIFT(BS)) u_rtt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int unsigned period(input int unsigned p, input int unsigned m);
    return (m + 1) << (BS + p);
  endfunction

  task automatic check(input string tag, input int unsigned got, input int unsigned exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write lands on the next rising edge, returns on the following falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1; wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 2'd1;
  endtask

  // R2: program, clear, then sample one cycle before and at the predicted edge
  task automatic measure(input logic [7:0] ctrl, input string tag);
    logic [7:0] v;
    int unsigned p;
    p = period(ctrl[6:4], ctrl[3:0]);
    wr(2'd0, ctrl);
    wr(2'd1, 8'h01);
    waitn(p - 2);
    rd(2'd1, v); check({tag, " R2 before"}, v[0], 0);
    waitn(1);
    rd(2'd1, v); check({tag, " R2 at edge"}, v[0], 1);
    check({tag, " R9 irq level"}, irq, en_model);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd1; wdata = 8'h00;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reset reg", v, 0);
    end
    check("R1 irq", irq, 0);

    // R3 field layout and bit 7
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R3 ctrl msb", v, 8'h7F);
    wr(2'd0, 8'h35); rd(2'd0, v); check("R3 ctrl fields", v, 8'h35);
    wr(2'd3, 8'hFF); rd(2'd3, v); check("R3 spare", v, 0);
    wr(2'd0, 8'h00);

    // boundary periods
    measure(8'h10, "shortest");
    measure(8'h7F, "longest");

    // R6 set and clear in the same cycle
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h01);
    waitn(period(1, 0) - 2);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R6 set wins", v[0], 1);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R5 clear", v[0], 0);

    // R8 restart
    wr(2'd0, 8'h21);
    wr(2'd1, 8'h01);
    waitn(20);
    wr(2'd0, 8'h21);
    waitn(period(2, 1) - 1);
    rd(2'd1, v); check("R8 no early flag", v[0], 0);
    waitn(1);
    rd(2'd1, v); check("R8 flag after restart", v[0], 1);

    // R5 zero writes, R4 sticky while stopped
    wr(2'd1, 8'h00); rd(2'd1, v); check("R5 write zero", v[0], 1);
    wr(2'd1, 8'hFE); rd(2'd1, v); check("R5 write FE", v[0], 1);
    wr(2'd0, 8'h00);
    waitn(500);
    rd(2'd1, v); check("R4 sticky", v[0], 1);

    // R7 stopped timer
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0F);
    waitn(3000);
    rd(2'd1, v); check("R7 stopped", v[0], 0);

    // R9 irq level
    wr(2'd2, 8'h01); en_model = 1'b1;
    check("R9 irq no flag", irq, 0);
    measure(8'h10, "irq");
    wr(2'd2, 8'h00); en_model = 1'b0;
    check("R9 irq disabled", irq, 0);
    rd(2'd2, v); check("R3 enable read", v, 0);
    wr(2'd2, 8'h01); en_model = 1'b1;
    check("R9 irq re-enabled", irq, 1);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    check("R9 irq after clear", irq, 0);

    // random periods, two consecutive periods each
    for (int i = 0; i < 12; i++) begin
      logic [7:0] c;
      int unsigned p;
      c = {1'b0, 3'(1 + ($urandom % 5)), 4'($urandom % 16)};
      en_model = 1'($urandom % 2);
      wr(2'd2, {7'd0, en_model});
      measure(c, "random");
      p = period(c[6:4], c[3:0]);
      wr(2'd1, 8'h01);
      waitn(p - 2);
      rd(2'd1, v); check("random R2 second before", v[0], 0);
      waitn(1);
      rd(2'd1, v); check("random R2 second edge", v[0], 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule